// File: doc/BRIEF.md
# DMA Controller Register Port

This block is the processor-facing programming port of a four-channel DMA controller. A host reaches it through chip select, separate read and write strobes, a 4-bit register address and an 8-bit data bus. Each channel owns a 16-bit address register and a 16-bit word-count register. Each has a base and a current copy. Because the data path is only one byte wide, an internal byte pointer flip-flop acts as a fifth address bit. It picks the low or the high half of a 16-bit register, and it toggles after every byte access to one.

The upper half of the address space holds a command byte, the per-channel mode fields, the channel mask and a set of data-less commands. These commands act on address and strobe alone: set or clear the byte pointer, master clear, clear all masks, and rewind the mode read-back counter. The whole port only listens while hold acknowledge is low, which means the transfer engine does not own the bus. The base, current, mode, mask and command contents are brought out in parallel for the transfer engine. A pulse tells that engine to return to idle after a master clear.

Top module: `dma_regport`

## Requirements
- R1: After reset every base and current register, every mode field, the command byte and the mode read-back counter are zero. All four mask bits are one, the byte pointer is clear, `dout_oe` is low and `seq_clear` is low.
- R2: An access counts only if `cs_n` and `hlda` are low and exactly one strobe is low until the strobe is released. A write made while `hlda` is high changes nothing. So does a write whose `cs_n` or `hlda` goes inactive mid-strobe, or a write made with both strobes low.
- R3: For addresses 0x0 to 0x7, bits [2:1] select the channel and bit 0 selects the address register (0) or the count register (1). A write loads the chosen byte into both the base and the current copy. A read returns the chosen byte of the current copy.
- R4: A byte pointer value of 0 selects bits [7:0] and 1 selects bits [15:8]. Every completed read or write at addresses 0x0 to 0x7 inverts the pointer, so after a clear the low byte comes first.
- R5: A write takes effect at the first clock edge that samples the write strobe high after a qualified low phase. While the strobe is still low, no register changes.
- R6: `dout_oe` is high, and `dout` carries read data, only while `cs_n`, `rd_n` and `hlda` are low and `wr_n` is high. Otherwise `dout` is zero.
- R7: A write to 0xC clears the byte pointer and a read of 0xC sets it. Both ignore the data bus, and the read returns zero.
- R8: A write to 0xD is a master clear. The data bus is ignored. It restores every R1 value and raises `seq_clear` for exactly one cycle, in the cycle the clear becomes visible.
- R9: A write to 0xE clears all mask bits and ignores the data. A write to 0xA sets (data bit 2 = 1) or clears the mask bit of channel data[1:0]. A write to 0xF loads data[3:0] into the mask. A read of 0xF returns {4'b0, mask}.
- R10: A write to 0xB stores data[7:2] as the mode of channel data[1:0]. A read of 0xB returns {mode[ptr], ptr[1:0]} and then advances the 2-bit read-back counter `ptr` modulo 4. A read of 0xE resets that counter to 0.
- R11: A write to 0x8 stores the command byte. A read of 0x8 returns it. The other upper addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hlda | input | 1 | Hold acknowledge; high blocks the port |
| addr | input | 4 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_oe | output | 1 | Read data valid / drive enable |
| base_addr_o | output | 64 | Base address registers, channel n at [16n+15:16n] |
| cur_addr_o | output | 64 | Current address registers |
| base_cnt_o | output | 64 | Base word-count registers |
| cur_cnt_o | output | 64 | Current word-count registers |
| mode_o | output | 24 | Mode fields, channel n at [6n+5:6n] |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| seq_clear | output | 1 | One-cycle return-to-idle pulse after master clear |

## Verification
Two things can meet in the same cycle: the release of a write strobe, and the bus being taken away, either because hold acknowledge rises or because chip select drops while the strobe is still low. The bench provokes this by raising `hlda` or `cs_n` mid-strobe, and also by holding both strobes low at once. It judges the outcome by comparing every parallel register output, and the later byte-pointer order, with a model that treats such a cycle as never having happened. A second collision, a byte access together with a pointer command, cannot happen on this single bus. Instead the bench alternates the two densely in random order.

// File: rtl/dma_rp_pkg.sv
package dma_rp_pkg;
  localparam int REG_W = 16;
  localparam int BUS_W = 8;
  localparam int ADR_W = 4;

  localparam logic [ADR_W-1:0] A_CMD   = 4'h8;
  localparam logic [ADR_W-1:0] A_SMASK = 4'hA;
  localparam logic [ADR_W-1:0] A_MODE  = 4'hB;
  localparam logic [ADR_W-1:0] A_PTR   = 4'hC;
  localparam logic [ADR_W-1:0] A_MCLR  = 4'hD;
  localparam logic [ADR_W-1:0] A_MZERO = 4'hE;
  localparam logic [ADR_W-1:0] A_AMASK = 4'hF;

  // replace one byte of a 16-bit register, hi selects the upper byte
  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] old,
                                                 input logic hi,
                                                 input logic [BUS_W-1:0] b);
    return hi ? {b, old[BUS_W-1:0]} : {old[REG_W-1:BUS_W], b};
  endfunction

  function automatic logic [BUS_W-1:0] get_byte(input logic [REG_W-1:0] v,
                                                 input logic hi);
    return hi ? v[REG_W-1:BUS_W] : v[BUS_W-1:0];
  endfunction
endpackage

// File: rtl/dma_rp_strobe.sv
module dma_rp_strobe
  import dma_rp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             hlda,
  input  logic [ADR_W-1:0] addr,
  input  logic [BUS_W-1:0] din,
  output logic             rd_live,
  output logic             wr_done,
  output logic             rd_done,
  output logic [ADR_W-1:0] ev_addr,
  output logic [BUS_W-1:0] ev_data
);
  logic prog_ok;
  logic wr_live;
  logic wr_arm, rd_arm;

  assign prog_ok = !cs_n && !hlda;
  assign wr_live = prog_ok && !wr_n && rd_n;
  assign rd_live = prog_ok && !rd_n && wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_arm  <= 1'b0;
      rd_arm  <= 1'b0;
      ev_addr <= '0;
      ev_data <= '0;
    end else begin
      wr_arm <= wr_live;
      rd_arm <= rd_live;
      if (wr_live || rd_live) begin
        ev_addr <= addr;
        ev_data <= din;
      end
    end
  end

  // a qualified strobe completes at the first edge that sees it released
  assign wr_done = wr_arm && wr_n;
  assign rd_done = rd_arm && rd_n;
endmodule

// File: rtl/dma_rp_decode.sv
module dma_rp_decode
  import dma_rp_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             wr_done,
  input  logic             rd_done,
  input  logic [ADR_W-1:0] ev_addr,
  output logic [NCH-1:0]   ch_wr,
  output logic             word_acc,
  output logic             ptr_clr,
  output logic             ptr_set,
  output logic             mclr,
  output logic             mask_zero,
  output logic             mask_one,
  output logic             mask_all,
  output logic             mode_wr,
  output logic             mode_rd,
  output logic             mrd_rewind,
  output logic             cmd_wr
);
  localparam int CHW = $clog2(NCH);

  logic word_hit;
  assign word_hit = !ev_addr[ADR_W-1];
  assign word_acc = (wr_done || rd_done) && word_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_wr[i] = wr_done && word_hit && (ev_addr[CHW:1] == CHW'(i));
  end

  assign cmd_wr     = wr_done && (ev_addr == A_CMD);
  assign mask_one   = wr_done && (ev_addr == A_SMASK);
  assign mode_wr    = wr_done && (ev_addr == A_MODE);
  assign mode_rd    = rd_done && (ev_addr == A_MODE);
  assign ptr_clr    = wr_done && (ev_addr == A_PTR);
  assign ptr_set    = rd_done && (ev_addr == A_PTR);
  assign mclr       = wr_done && (ev_addr == A_MCLR);
  assign mask_zero  = wr_done && (ev_addr == A_MZERO);
  assign mrd_rewind = rd_done && (ev_addr == A_MZERO);
  assign mask_all   = wr_done && (ev_addr == A_AMASK);
endmodule

// File: rtl/dma_rp_chan.sv
module dma_rp_chan
  import dma_rp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic             sel_cnt,
  input  logic             hi,
  input  logic [BUS_W-1:0] data,
  output logic [REG_W-1:0] base_a,
  output logic [REG_W-1:0] cur_a,
  output logic [REG_W-1:0] base_c,
  output logic [REG_W-1:0] cur_c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a <= '0;
      cur_a  <= '0;
      base_c <= '0;
      cur_c  <= '0;
    end else if (clr) begin
      base_a <= '0;
      cur_a  <= '0;
      base_c <= '0;
      cur_c  <= '0;
    end else if (we) begin
      if (sel_cnt) begin
        base_c <= put_byte(base_c, hi, data);
        cur_c  <= put_byte(cur_c, hi, data);
      end else begin
        base_a <= put_byte(base_a, hi, data);
        cur_a  <= put_byte(cur_a, hi, data);
      end
    end
  end
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_rp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int MW  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic                   hlda,
  input  logic [ADR_W-1:0]       addr,
  input  logic [BUS_W-1:0]       din,
  output logic [BUS_W-1:0]       dout,
  output logic                   dout_oe,
  output logic [NCH*REG_W-1:0]   base_addr_o,
  output logic [NCH*REG_W-1:0]   cur_addr_o,
  output logic [NCH*REG_W-1:0]   base_cnt_o,
  output logic [NCH*REG_W-1:0]   cur_cnt_o,
  output logic [NCH*MW-1:0]      mode_o,
  output logic [NCH-1:0]         mask_o,
  output logic [BUS_W-1:0]       cmd_o,
  output logic                   seq_clear
);
  localparam int CHW = $clog2(NCH);

  logic             rd_live, wr_done, rd_done;
  logic [ADR_W-1:0] ev_addr;
  logic [BUS_W-1:0] ev_data;
  logic [NCH-1:0]   ch_wr;
  logic word_acc, ptr_clr, ptr_set, mclr, mask_zero, mask_one, mask_all;
  logic mode_wr, mode_rd, mrd_rewind, cmd_wr;

  logic             ff;
  logic [NCH-1:0]   mask_q;
  logic [MW-1:0]    mode_q [NCH];
  logic [CHW-1:0]   mptr;
  logic [BUS_W-1:0] cmd_q;

  dma_rp_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hlda(hlda), .addr(addr), .din(din), .rd_live(rd_live),
    .wr_done(wr_done), .rd_done(rd_done), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  dma_rp_decode #(.NCH(NCH)) u_dec (
    .wr_done(wr_done), .rd_done(rd_done), .ev_addr(ev_addr), .ch_wr(ch_wr),
    .word_acc(word_acc), .ptr_clr(ptr_clr), .ptr_set(ptr_set), .mclr(mclr),
    .mask_zero(mask_zero), .mask_one(mask_one), .mask_all(mask_all),
    .mode_wr(mode_wr), .mode_rd(mode_rd), .mrd_rewind(mrd_rewind),
    .cmd_wr(cmd_wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_rp_chan u_ch (
      .clk(clk), .rst_n(rst_n), .clr(mclr), .we(ch_wr[i]),
      .sel_cnt(ev_addr[0]), .hi(ff), .data(ev_data),
      .base_a(base_addr_o[i*REG_W +: REG_W]),
      .cur_a (cur_addr_o [i*REG_W +: REG_W]),
      .base_c(base_cnt_o [i*REG_W +: REG_W]),
      .cur_c (cur_cnt_o  [i*REG_W +: REG_W])
    );
    assign mode_o[i*MW +: MW] = mode_q[i];
  end

  // byte pointer: master clear wins, then the explicit commands, then toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ff <= 1'b0;
    else if (mclr || ptr_clr)  ff <= 1'b0;
    else if (ptr_set)          ff <= 1'b1;
    else if (word_acc)         ff <= ~ff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '1;
    else if (mclr)       mask_q <= '1;
    else if (mask_zero)  mask_q <= '0;
    else if (mask_all)   mask_q <= ev_data[NCH-1:0];
    else if (mask_one)   mask_q[ev_data[CHW-1:0]] <= ev_data[CHW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else if (mclr) begin
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else if (mode_wr) begin
      mode_q[ev_data[CHW-1:0]] <= ev_data[BUS_W-1 -: MW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mptr <= '0;
    else if (mclr || mrd_rewind) mptr <= '0;
    else if (mode_rd)            mptr <= mptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      seq_clear <= 1'b0;
    end else begin
      seq_clear <= mclr;
      if (mclr)        cmd_q <= '0;
      else if (cmd_wr) cmd_q <= ev_data;
    end
  end

  assign mask_o = mask_q;
  assign cmd_o  = cmd_q;

  // read path follows the live address while the read strobe is qualified
  logic [CHW-1:0]   rd_ch;
  logic [REG_W-1:0] rd_word;
  assign rd_ch   = addr[CHW:1];
  assign dout_oe = rd_live;

  always_comb begin
    rd_word = addr[0] ? cur_cnt_o[rd_ch*REG_W +: REG_W]
                      : cur_addr_o[rd_ch*REG_W +: REG_W];
    dout = '0;
    if (rd_live) begin
      if (!addr[ADR_W-1]) begin
        dout = get_byte(rd_word, ff);
      end else begin
        case (addr)
          A_CMD:   dout = cmd_q;
          A_MODE:  dout = BUS_W'({mode_q[mptr], mptr});
          A_AMASK: dout = BUS_W'(mask_q);
          default: dout = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_regport_chk.sv
module dma_regport_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           rd_n,
  input logic           wr_n,
  input logic           hlda,
  input logic           dout_oe,
  input logic           ff,
  input logic           word_acc,
  input logic           ptr_clr,
  input logic           ptr_set,
  input logic           mclr,
  input logic           mask_zero,
  input logic [NCH-1:0] mask_o,
  input logic           seq_clear,
  input logic           wr_done,
  input logic           rd_done
);
  AST_OE_NEEDS_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!cs_n && !rd_n && wr_n && !hlda)); // R6
  AST_HOLD_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && $past(hlda)) |-> (!wr_done && !rd_done)); // R2
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_done, rd_done})); // R5
  AST_PTR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    word_acc |=> (ff != $past(ff))); // R4
  AST_PTR_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ff); // R7
  AST_PTR_SET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_set |=> ff); // R7
  AST_MCLR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (!ff && (&mask_o) && seq_clear)); // R8
  AST_MCLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clear |=> !seq_clear); // R8
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_zero |=> (mask_o == '0)); // R9
endmodule

bind dma_regport dma_regport_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .hlda(hlda), .dout_oe(dout_oe), .ff(ff), .word_acc(word_acc),
  .ptr_clr(ptr_clr), .ptr_set(ptr_set), .mclr(mclr), .mask_zero(mask_zero),
  .mask_o(mask_o), .seq_clear(seq_clear), .wr_done(wr_done), .rd_done(rd_done)
);

// File: tb/sim_dma_regport.sv
module sim_dma_regport;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cs_n, rd_n, wr_n, hlda;
  logic [3:0]  addr;
  logic [7:0]  din, dout;
  logic        dout_oe, seq_clear;
  logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
  logic [23:0] mode_o;
  logic [3:0]  mask_o;
  logic [7:0]  cmd_o;

  dma_regport u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hlda(hlda), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
    .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o), .mode_o(mode_o),
    .mask_o(mask_o), .cmd_o(cmd_o), .seq_clear(seq_clear)
  );

  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  // reference model
  logic [15:0] m_a [4];
  logic [15:0] m_c [4];
  logic        m_ff;
  logic [3:0]  m_mask;
  logic [5:0]  m_mode [4];
  logic [1:0]  m_ptr;
  logic [7:0]  m_cmd;
  logic        last_sc;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_a[i] = '0; m_c[i] = '0; m_mode[i] = '0;
    end
    m_ff = 1'b0; m_mask = 4'hF; m_ptr = '0; m_cmd = '0;
  endtask

  function automatic logic [15:0] ins_byte(input logic [15:0] v, input logic hi, input logic [7:0] b);
    logic [15:0] r;
    r = v;
    if (hi) r[15:8] = b; else r[7:0] = b;
    return r;
  endfunction

  function automatic logic [63:0] pack_a();
    return {m_a[3], m_a[2], m_a[1], m_a[0]};
  endfunction
  function automatic logic [63:0] pack_c();
    return {m_c[3], m_c[2], m_c[1], m_c[0]};
  endfunction
  function automatic logic [23:0] pack_mode();
    return {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    if (!a[3]) begin
      if (a[0]) m_c[a[2:1]] = ins_byte(m_c[a[2:1]], m_ff, d);
      else      m_a[a[2:1]] = ins_byte(m_a[a[2:1]], m_ff, d);
      m_ff = ~m_ff;
    end else begin
      case (a)
        4'h8: m_cmd = d;
        4'hA: m_mask[d[1:0]] = d[2];
        4'hB: m_mode[d[1:0]] = d[7:2];
        4'hC: m_ff = 1'b0;
        4'hD: model_clear();
        4'hE: m_mask = 4'h0;
        4'hF: m_mask = d[3:0];
        default: ;
      endcase
    end
  endtask

  // expected read value, then the read's side effects
  task automatic model_rd(input logic [3:0] a, output logic [7:0] v);
    v = 8'h00;
    if (!a[3]) begin
      logic [15:0] w;
      w = a[0] ? m_c[a[2:1]] : m_a[a[2:1]];
      v = m_ff ? w[15:8] : w[7:0];
      m_ff = ~m_ff;
    end else begin
      case (a)
        4'h8: v = m_cmd;
        4'hB: begin v = {m_mode[m_ptr], m_ptr}; m_ptr = m_ptr + 2'd1; end
        4'hC: m_ff = 1'b1;
        4'hE: m_ptr = 2'd0;
        4'hF: v = {4'h0, m_mask};
        default: ;
      endcase
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " cur addr"},  cur_addr_o,  pack_a());
    chk({tag, " base addr"}, base_addr_o, pack_a());
    chk({tag, " cur cnt"},   cur_cnt_o,   pack_c());
    chk({tag, " base cnt"},  base_cnt_o,  pack_c());
    chk({tag, " mask"},      mask_o,      m_mask);
    chk({tag, " mode"},      mode_o,      pack_mode());
    chk({tag, " cmd"},       cmd_o,       m_cmd);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                           input logic hold, input logic both);
    @(negedge clk);
    hlda = hold; cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
    if (both) rd_n = 1'b0;
    @(negedge clk);
    if (both) chk("R6 oe with both strobes", dout_oe, 1'b0);
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    last_sc = seq_clear;
    cs_n = 1'b1; hlda = 1'b0;
    if (!hold && !both) model_wr(a, d);
  endtask

  task automatic bus_read(input logic [3:0] a, input logic hold, input string tag);
    logic [7:0] got, exp;
    logic oe;
    @(negedge clk);
    hlda = hold; cs_n = 1'b0; addr = a; rd_n = 1'b0; din = 8'($urandom);
    @(negedge clk);
    got = dout; oe = dout_oe;
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; hlda = 1'b0;
    if (hold) begin
      chk({tag, " R6 oe under hold"}, oe, 1'b0);
      chk({tag, " R6 dout under hold"}, got, 8'h00);
    end else begin
      model_rd(a, exp);
      chk({tag, " R6 oe"}, oe, 1'b1);
      chk({tag, " read data"}, got, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; hlda = 1'b0;
    addr = '0; din = '0; last_sc = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    chk("R1 oe", dout_oe, 1'b0);
    chk("R1 seq_clear", seq_clear, 1'b0);

    // R3 R4: low byte then high byte of channel 1 address
    bus_write(4'h2, 8'h34, 1'b0, 1'b0);
    bus_write(4'h2, 8'h12, 1'b0, 1'b0);
    chk("R3 ch1 addr word", cur_addr_o[31:16], 16'h1234);
    chk("R4 ch1 base word", base_addr_o[31:16], 16'h1234);
    bus_read(4'h2, 1'b0, "R4 low first");
    bus_read(4'h2, 1'b0, "R4 high second");

    // R7: pointer clear with junk data, then overwrite low byte
    bus_write(4'h5, 8'hAA, 1'b0, 1'b0);
    bus_write(4'hC, 8'hFF, 1'b0, 1'b0);
    bus_write(4'h5, 8'h5C, 1'b0, 1'b0);
    chk("R7 clear restarts low byte", cur_cnt_o[47:32], 16'h005C);
    bus_read(4'hC, 1'b0, "R7 set via read");
    bus_read(4'h5, 1'b0, "R7 high byte after set");
    check_state("R7");

    // R9 masks
    bus_write(4'hE, 8'hFF, 1'b0, 1'b0);
    chk("R9 mask cleared ignoring data", mask_o, 4'h0);
    bus_write(4'hA, 8'b0000_0111, 1'b0, 1'b0);
    chk("R9 single set ch3", mask_o, 4'h8);
    bus_write(4'hF, 8'hA5, 1'b0, 1'b0);
    bus_read(4'hF, 1'b0, "R9 mask readback");

    // R10 mode and readback counter
    for (int i = 0; i < 4; i++) bus_write(4'hB, {6'(8 * i + 3), 2'(i)}, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) bus_read(4'hB, 1'b0, "R10 mode walk");
    bus_read(4'hE, 1'b0, "R10 rewind");
    bus_read(4'hB, 1'b0, "R10 after rewind");

    // R11 command byte
    bus_write(4'h8, 8'hC3, 1'b0, 1'b0);
    bus_read(4'h8, 1'b0, "R11 cmd");
    bus_read(4'h9, 1'b0, "R11 unused reads zero");

    // R2: hold, both strobes, hold rising mid-strobe, cs lost mid-strobe
    bus_write(4'h0, 8'h77, 1'b1, 1'b0);
    bus_write(4'h0, 8'h66, 1'b0, 1'b1);
    check_state("R2 blocked writes");
    @(negedge clk); cs_n = 1'b0; addr = 4'h0; din = 8'h99; wr_n = 1'b0;
    @(negedge clk); hlda = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; hlda = 1'b0;
    @(negedge clk); cs_n = 1'b0; addr = 4'h0; din = 8'h98; wr_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    check_state("R2 aborted writes");
    bus_read(4'h0, 1'b0, "R2 pointer untouched by aborts");

    // R5: nothing changes while strobe still low
    @(negedge clk); cs_n = 1'b0; addr = 4'h6; din = 8'h4E; wr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 no change during strobe", cur_addr_o[63:48], m_a[3]);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    model_wr(4'h6, 8'h4E);
    chk("R5 change after release", cur_addr_o[63:48], m_a[3]);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] a;
      logic hold;
      a = 4'($urandom);
      hold = ($urandom % 8) == 0;
      if (a == 4'hD && ($urandom % 4) != 0) a = 4'hC;
      if ($urandom % 2) bus_write(a, 8'($urandom), hold, ($urandom % 16) == 0);
      else              bus_read(a, hold, "R3 random read");
      if (k % 20 == 19) check_state("R3 random state");
    end

    // R8 master clear with junk data
    bus_write(4'hD, 8'h5A, 1'b0, 1'b0);
    chk("R8 seq_clear pulse", last_sc, 1'b1);
    check_state("R8");
    @(negedge clk);
    chk("R8 pulse one cycle", seq_clear, 1'b0);
    bus_read(4'h1, 1'b0, "R8 pointer cleared");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule